// File: doc/BRIEF.md
# Saturating Error Counter Bank

This block keeps a tally of four kinds of line-error events: parity errors, disagreement errors, line code violations and frame errors. Each kind comes in as a single-cycle pulse and feeds its own 8-bit counter. By default a counter stops at full scale and latches an interrupt flag. The line-code-violation and frame-error counters can also run in a wrapping mode, set at run time. In that mode they roll over from full scale to zero, latch no flag, and give a one-clock carry pulse.

Each counter has an interrupt enable. One active-high output merges every enabled, latched flag. A host reads a counter by giving its index together with a read strobe. The selected count is always visible on the read data port. The edge that takes the strobe clears that count and its flag. An event that arrives in the same cycle as the read is counted into the freshly cleared counter.

Top module: `err_counter_bank`

## Requirements
- R1: After reset every count is 0, `irq_o` is low and every `carry_o` bit is low.
- R2: A high `evt_i[i]` at a clock edge adds one to counter i. The index order is 0 = parity, 1 = disagreement, 2 = line code violation, 3 = frame error. `rd_data_o` shows the count of the counter picked by `rd_sel_i`, with no extra cycle of delay.
- R3: In saturating mode, a counter that holds 255 stays at 255 on further events. Its flag latches at the edge where the count becomes 255. Counters 0 and 1 always saturate. Counters 2 and 3 saturate while `wrap_en_i` is low.
- R4: While `wrap_en_i` is high, counters 2 and 3 go from 255 to 0 on an event and never latch their flag.
- R5: `carry_o[i]` is high for exactly the one cycle after the edge at which counter i wrapped. `carry_o[0]` and `carry_o[1]` stay low.
- R6: `irq_o` is the OR, over all counters, of each latched flag ANDed with `irq_en_i[i]`. A change of enable takes effect in the same cycle. A flag is kept while its enable is low.
- R7: A clock edge with `rd_stb_i` high clears the count and the flag of the counter selected by `rd_sel_i`. The other counters are left unchanged.
- R8: An event on the selected counter in the same cycle as a read leaves that counter at 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 4 | Error event pulses, one per counter |
| wrap_en_i | input | 1 | Selects wrap-with-carry mode for counters 2 and 3 |
| irq_en_i | input | 4 | Per-counter interrupt enables |
| rd_stb_i | input | 1 | Read strobe; clears the selected counter |
| rd_sel_i | input | 2 | Index of the counter to read |
| rd_data_o | output | 8 | Count of the selected counter |
| carry_o | output | 4 | One-cycle wrap pulses |
| irq_o | output | 1 | Shared counter interrupt |

## Verification
A count that is off by one, or a value that was not cleared, shows on `rd_data_o` as soon as that counter is selected. The bench keeps the selection moving, so such an error appears within a few cycles. A wrong flag shows on `irq_o` in the same cycle in which its enable is high. A missed wrap or a doubled carry shows on `carry_o` in the cycle after the edge. A saturation fault shows only after 255 events, so the bench drives counters all the way to full scale on purpose.

// File: rtl/errbank_pkg.sv
package errbank_pkg;
  typedef enum int unsigned {
    CTR_PARITY   = 0,
    CTR_DISAGREE = 1,
    CTR_LCV      = 2,
    CTR_FERR     = 3
  } ctr_id_e;

  localparam int unsigned DEF_NUM_CTR = 4;
  localparam int unsigned DEF_CNT_W   = 8;
endpackage

// File: rtl/tally_cell.sv
module tally_cell #(
  parameter int unsigned CNT_W   = 8,
  parameter bit          WRAP_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic             wrap_mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o,
  output logic             carry_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  // {carry, next value} for one step from v
  function automatic logic [CNT_W:0] step(input logic [CNT_W-1:0] v,
                                          input logic inc,
                                          input logic may_wrap);
    logic [CNT_W:0] r;
    if (!inc)           r = {1'b0, v};
    else if (v != MAX)  r = {1'b0, v + 1'b1};
    else if (may_wrap)  r = {1'b1, {CNT_W{1'b0}}};
    else                r = {1'b0, MAX};
    return r;
  endfunction

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;
  logic             wrap_active;
  logic             wrap_now;
  logic             sat_hit;
  logic             flag_d;

  assign wrap_active      = WRAP_OK && wrap_mode_i;
  assign base             = clr_i ? '0 : count_o;
  assign {wrap_now, nxt}  = step(base, evt_i, wrap_active);
  assign sat_hit          = !wrap_active && evt_i && (nxt == MAX);
  assign flag_d           = (flag_o && !clr_i) || sat_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      flag_o  <= 1'b0;
      carry_o <= 1'b0;
    end else begin
      count_o <= nxt;
      flag_o  <= flag_d;
      carry_o <= wrap_now;
    end
  end

  // R3: saturating counter at full scale holds
  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_active && count_o == MAX && !clr_i) |=> (count_o == MAX));
  // R3: a fresh flag appears only with a full-scale count
  a_r3_flag_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> (count_o == MAX));
  // R5: carry is a single-cycle pulse and marks a zero count
  a_r5_carry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);
  a_r5_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (count_o == '0));
  // R4: no flag set by a wrap-mode event
  a_r4_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_active && !flag_o) |=> !flag_o);
  // R7: read without event clears count and flag
  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> (count_o == '0 && !flag_o));
  // R8: read with event leaves one
  a_r8_read_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && evt_i) |=> (count_o == {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N-1:0] gated;
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = flag_i[g] & en_i[g];
  end
  assign irq_o = |gated;
endmodule

// File: rtl/read_mux.sv
module read_mux #(
  parameter int unsigned N     = 4,
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N*W-1:0]  counts_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [W-1:0]    data_o
);
  always_comb begin
    data_o = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SEL_W'(k)) data_o = counts_i[k*W +: W];
    end
  end
endmodule

// File: rtl/err_counter_bank.sv
module err_counter_bank
  import errbank_pkg::*;
#(
  parameter int unsigned         NUM_CTR   = DEF_NUM_CTR,
  parameter int unsigned         CNT_W     = DEF_CNT_W,
  parameter logic [NUM_CTR-1:0]  WRAP_MASK = 4'b1100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CTR-1:0]         evt_i,
  input  logic                       wrap_en_i,
  input  logic [NUM_CTR-1:0]         irq_en_i,
  input  logic                       rd_stb_i,
  input  logic [$clog2(NUM_CTR)-1:0] rd_sel_i,
  output logic [CNT_W-1:0]           rd_data_o,
  output logic [NUM_CTR-1:0]         carry_o,
  output logic                       irq_o
);
  localparam int unsigned SEL_W = $clog2(NUM_CTR);

  logic [NUM_CTR*CNT_W-1:0] counts;
  logic [NUM_CTR-1:0]       flags;
  logic [NUM_CTR-1:0]       clr_hit;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign clr_hit[i] = rd_stb_i && (rd_sel_i == SEL_W'(i));
    tally_cell #(
      .CNT_W  (CNT_W),
      .WRAP_OK(WRAP_MASK[i])
    ) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i[i]),
      .clr_i      (clr_hit[i]),
      .wrap_mode_i(wrap_en_i),
      .count_o    (counts[i*CNT_W +: CNT_W]),
      .flag_o     (flags[i]),
      .carry_o    (carry_o[i])
    );
  end

  irq_merge #(.N(NUM_CTR)) u_irq (
    .flag_i(flags),
    .en_i  (irq_en_i),
    .irq_o (irq_o)
  );

  read_mux #(.N(NUM_CTR), .W(CNT_W), .SEL_W(SEL_W)) u_rd (
    .counts_i(counts),
    .sel_i   (rd_sel_i),
    .data_o  (rd_data_o)
  );

  // R6: with every enable low the shared line is quiet
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_i == '0) |-> !irq_o);
  // R5: counters without wrap capability never carry
  a_r5_no_carry_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_o & ~WRAP_MASK) == '0);
  // R7: a read strobe selects exactly one counter
  a_r7_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_hit));
endmodule

// File: tb/err_counter_bank_tb.sv
module err_counter_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_i = '0;
  logic       wrap_en_i = 1'b0;
  logic [3:0] irq_en_i = '0;
  logic       rd_stb_i = 1'b0;
  logic [1:0] rd_sel_i = '0;
  logic [7:0] rd_data_o;
  logic [3:0] carry_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  int m_cnt [4];
  bit m_flag [4];
  bit m_carry [4];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wrap_en_i(wrap_en_i),
    .irq_en_i(irq_en_i), .rd_stb_i(rd_stb_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .carry_o(carry_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare outputs with the model (called away from the rising edge)
  task automatic compare();
    bit exp_irq = 0;
    int exp_carry = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_flag[i] && irq_en_i[i]) exp_irq = 1;
      if (m_carry[i]) exp_carry |= (1 << i);
    end
    chk("R2/R7 rd_data", int'(rd_data_o), m_cnt[rd_sel_i]);
    chk("R6 irq", int'(irq_o), int'(exp_irq));
    chk("R5 carry", int'(carry_o), exp_carry);
  endtask

  // advance the model by one edge with the present inputs
  task automatic model_step();
    for (int i = 0; i < 4; i++) begin
      bit rd = rd_stb_i && (int'(rd_sel_i) == i);
      bit wr = wrap_en_i && (i >= 2);
      int b = rd ? 0 : m_cnt[i];
      bit f = rd ? 0 : m_flag[i];
      m_carry[i] = 0;
      if (evt_i[i]) begin
        if (b < 255) b = b + 1;
        else if (wr) begin b = 0; m_carry[i] = 1; end
        if (!wr && b == 255) f = 1;
      end
      m_cnt[i] = b;
      m_flag[i] = f;
    end
  endtask

  task automatic cycle(input logic [3:0] e, input logic rd, input logic [1:0] sel);
    evt_i = e; rd_stb_i = rd; rd_sel_i = sel;
    model_step();
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; rd_stb_i = 1'b0;
    compare();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_flag[i] = 0; m_carry[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel_i = 2'(s); #0.1;
      chk("R1 count", int'(rd_data_o), 0);
    end
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 carry", int'(carry_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    // R2: count parity events while viewing parity
    for (int k = 0; k < 10; k++) cycle(4'b0001, 1'b0, 2'd0);
    chk("R2 parity ten", int'(rd_data_o), 10);

    // R3: saturate parity, flag latched, gated by R6
    irq_en_i = 4'b0000;
    for (int k = 0; k < 250; k++) cycle(4'b0001, 1'b0, 2'd0);
    chk("R3 at max", int'(rd_data_o), 255);
    chk("R6 disabled keeps quiet", int'(irq_o), 0);
    irq_en_i = 4'b0001; #0.1;
    chk("R6 enable shows flag", int'(irq_o), 1);
    cycle(4'b0001, 1'b0, 2'd0);
    chk("R3 holds at max", int'(rd_data_o), 255);

    // R7: read clears parity and its flag
    cycle(4'b0000, 1'b1, 2'd0);
    chk("R7 cleared", int'(rd_data_o), 0);
    chk("R7 flag cleared", int'(irq_o), 0);

    // R4/R5: wrap mode on line code violation counter
    wrap_en_i = 1'b1; irq_en_i = 4'b1111;
    for (int k = 0; k < 256; k++) cycle(4'b0100, 1'b0, 2'd2);
    chk("R4 wrapped to zero", int'(rd_data_o), 0);
    chk("R5 carry pulse", int'(carry_o), 4'b0100);
    chk("R4 no irq", int'(irq_o), 0);
    cycle(4'b0000, 1'b0, 2'd2);
    chk("R5 carry one cycle", int'(carry_o), 0);

    // R3: frame counter saturates with wrap off
    wrap_en_i = 1'b0;
    for (int k = 0; k < 260; k++) cycle(4'b1000, 1'b0, 2'd3);
    chk("R3 frame sat", int'(rd_data_o), 255);
    chk("R3 frame irq", int'(irq_o), 1);

    // R8: read with event on the same counter
    cycle(4'b1000, 1'b1, 2'd3);
    chk("R8 read plus event", int'(rd_data_o), 1);

    // R7: read of one counter leaves the others
    cycle(4'b0010, 1'b0, 2'd1);
    cycle(4'b0000, 1'b1, 2'd3);
    rd_sel_i = 2'd1; #0.1;
    chk("R7 other untouched", int'(rd_data_o), 1);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      if (k % 700 == 0) wrap_en_i = ~wrap_en_i;
      if (k % 97 == 0) irq_en_i = 4'($urandom);
      cycle(4'($urandom), ($urandom % 40) == 0, 2'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule